// File: doc/BRIEF.md
# Split-Security Channel Control Filter

This block holds the control state of an event-channel controller (the channel enable vector, the channel-group membership masks and the per-group subscription settings) and guards every access to it with per-channel security permissions. A 16-bit permission input marks each channel secure (1) or non-secure (0). Each bus access carries a secure flag. Secure accesses see and change everything. Non-secure accesses are filtered bit by bit on the channel enable registers. Whole accesses are dropped for groups that contain a secure channel. A blocked access is silently discarded or reads as zero, and never raises an error.

Group enable and disable tasks fire from bus writes or from pulses on subscribed channels. A pulse from a non-secure channel cannot fire a task of a secure group. A group is secure as soon as any of its member channels is marked secure in the permission input. This is recomputed every cycle from the current mask and permission input, whether the channels are enabled or not.

Top module: `chan_sec_filter`

## Requirements
- R1: While reset is active and after it is released, the enable vector, every group mask and every subscription word are zero.
- R2: A secure access (sec_i=1) reads and writes every register and every bit without any filtering.
- R3: A non-secure write to the enable, set or clear register leaves every bit of a secure channel unchanged. Writing 0 to a set or clear bit has no effect.
- R4: A non-secure read of the enable, set or clear register returns 0 in every bit of a secure channel and the enable state in the others.
- R5: A group is secure when its mask and the permission input share at least one set bit, whether or not that channel is enabled. Otherwise the group is non-secure.
- R6: For a secure group, a non-secure write to its enable task, disable task, mask or subscription words is ignored, and a non-secure read of its mask or subscription words returns 0.
- R7: A write to a group mask is ignored while either of that group's subscriptions is switched on.
- R8: An enable task sets every member channel of the group and a disable task clears them. The tasks act on the result of a same-cycle bus write to the enable registers. When an enable and a disable reach the same channel in one cycle, the enable wins.
- R9: A switched-on subscription fires its task when its channel pulses on ch_evt_i. A pulse from a non-secure channel is ignored when the group is secure. A pulse from a secure channel fires tasks of either kind of group.
- R10: Word address map, with g the group: 2g is the enable task, 2g+1 the disable task (a task fires on a write with data bit 0 set). 0x20+2g is the enable-task subscription and 0x21+2g the disable-task subscription, each with bit 31 for on and bits 3:0 for the channel. 0x40 is the enable register, 0x41 set, 0x42 clear (both read as the enable state). 0x60+g is the group mask. Channel i is data bit i. Unmapped and task addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| sec_i | input | 1 | 1 = secure access |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| perm_i | input | 16 | Per-channel secure mark |
| ch_evt_i | input | 16 | Channel pulses seen by subscriptions |
| rdata_o | output | 32 | Read data, combinational, 0 when no read |
| chen_o | output | 16 | Channel enable vector |

## Verification
A wrong enable bit shows on chen_o at the first clock edge after the access or pulse that caused it, and the per-cycle comparison catches it there. A mask or subscription word stored wrongly stays hidden until it is read back or used by a task. The bench therefore reads back every written word and fires tasks whose members cover both secure and non-secure channels. A wrong group-security decision shows as a read that is zero or non-zero when it should not be, or as a pulse or task that changes chen_o one cycle later when it should be ignored, or the other way round.

// File: rtl/chan_sec_filter_pkg.sv
package chan_sec_filter_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SUB_ON_BIT = 31;
  localparam logic [ADDR_W-1:0] TASK_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] SUB_BASE  = 8'h20;
  localparam logic [ADDR_W-1:0] CHEN_ADDR = 8'h40;
  localparam logic [ADDR_W-1:0] SET_ADDR  = 8'h41;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 8'h42;
  localparam logic [ADDR_W-1:0] MASK_BASE = 8'h60;
endpackage

// File: rtl/chan_sec_filter_grp.sv
module chan_sec_filter_grp #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] perm_i,
  input  logic              ns_i,
  input  logic              task_bit_i,
  input  logic              sub_on_i,
  input  logic [IDX_W-1:0]  sub_idx_i,
  input  logic [NUM_CH-1:0] mask_wdata_i,
  input  logic              wr_en_task_i,
  input  logic              wr_dis_task_i,
  input  logic              wr_sub_en_i,
  input  logic              wr_sub_dis_i,
  input  logic              wr_mask_i,
  input  logic [NUM_CH-1:0] ch_evt_i,
  output logic              en_req_o,
  output logic              dis_req_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic              sec_o,
  output logic              sub_en_on_o,
  output logic [IDX_W-1:0]  sub_en_idx_o,
  output logic              sub_dis_on_o,
  output logic [IDX_W-1:0]  sub_dis_idx_o
);
  logic [NUM_CH-1:0] mask_q;
  logic              en_on_q, dis_on_q;
  logic [IDX_W-1:0]  en_idx_q, dis_idx_q;
  logic              blocked, en_pulse, dis_pulse;

  // secure as soon as any member is secure, enabled or not
  assign sec_o   = |(mask_q & perm_i);
  assign blocked = ns_i & sec_o;

  // non-secure channel may not reach a secure group
  assign en_pulse  = en_on_q  && (int'(en_idx_q)  < NUM_CH) && ch_evt_i[en_idx_q]
                     && (perm_i[en_idx_q]  || !sec_o);
  assign dis_pulse = dis_on_q && (int'(dis_idx_q) < NUM_CH) && ch_evt_i[dis_idx_q]
                     && (perm_i[dis_idx_q] || !sec_o);

  assign en_req_o  = (wr_en_task_i  & task_bit_i & ~blocked) | en_pulse;
  assign dis_req_o = (wr_dis_task_i & task_bit_i & ~blocked) | dis_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      en_on_q   <= 1'b0;
      en_idx_q  <= '0;
      dis_on_q  <= 1'b0;
      dis_idx_q <= '0;
    end else begin
      if (wr_mask_i && !blocked && !en_on_q && !dis_on_q) mask_q <= mask_wdata_i;
      if (wr_sub_en_i && !blocked) begin
        en_on_q  <= sub_on_i;
        en_idx_q <= sub_idx_i;
      end
      if (wr_sub_dis_i && !blocked) begin
        dis_on_q  <= sub_on_i;
        dis_idx_q <= sub_idx_i;
      end
    end
  end

  assign mask_o        = mask_q;
  assign sub_en_on_o   = en_on_q;
  assign sub_en_idx_o  = en_idx_q;
  assign sub_dis_on_o  = dis_on_q;
  assign sub_dis_idx_o = dis_idx_q;
endmodule

// File: rtl/chan_sec_filter_chen.sv
module chan_sec_filter_chen #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] perm_i,
  input  logic              ns_i,
  input  logic              wr_chen_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [NUM_CH-1:0] wbits_i,
  input  logic [NUM_CH-1:0] grp_en_i,
  input  logic [NUM_CH-1:0] grp_dis_i,
  output logic [NUM_CH-1:0] chen_o
);
  logic [NUM_CH-1:0] chen_q, wmask, bits, bus_next;

  assign wmask = ns_i ? ~perm_i : '1;
  assign bits  = wbits_i & wmask;

  always_comb begin
    bus_next = chen_q;
    if (wr_chen_i)     bus_next = (chen_q & ~wmask) | bits;
    else if (wr_set_i) bus_next = chen_q | bits;
    else if (wr_clr_i) bus_next = chen_q & ~bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chen_q <= '0;
    else         chen_q <= (bus_next & ~grp_dis_i) | grp_en_i; // enable wins
  end

  assign chen_o = chen_q;
endmodule

// File: rtl/chan_sec_filter.sv
module chan_sec_filter
  import chan_sec_filter_pkg::*;
#(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned NUM_GRP = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] perm_i,
  input  logic [NUM_CH-1:0] ch_evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] chen_o
);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned PAD_W = DATA_W - 1 - IDX_W;

  logic acc_wr, acc_rd, ns;
  logic [NUM_GRP-1:0] en_req, dis_req, grp_sec, sub_en_on, sub_dis_on;
  logic [NUM_CH-1:0]  grp_mask [NUM_GRP];
  logic [IDX_W-1:0]   sub_en_idx [NUM_GRP];
  logic [IDX_W-1:0]   sub_dis_idx [NUM_GRP];
  logic [NUM_CH-1:0]  en_chs, dis_chs, rd_mask;
  logic               unused_wdata;

  assign acc_wr = req_i & we_i;
  assign acc_rd = req_i & ~we_i;
  assign ns     = ~sec_i;
  assign unused_wdata = ^wdata_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(int'(TASK_BASE) + 2*g);
    localparam logic [ADDR_W-1:0] A_DIS   = ADDR_W'(int'(TASK_BASE) + 2*g + 1);
    localparam logic [ADDR_W-1:0] A_SEN   = ADDR_W'(int'(SUB_BASE) + 2*g);
    localparam logic [ADDR_W-1:0] A_SDIS  = ADDR_W'(int'(SUB_BASE) + 2*g + 1);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(int'(MASK_BASE) + g);

    chan_sec_filter_grp #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_grp (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .perm_i        (perm_i),
      .ns_i          (ns),
      .task_bit_i    (wdata_i[0]),
      .sub_on_i      (wdata_i[SUB_ON_BIT]),
      .sub_idx_i     (wdata_i[IDX_W-1:0]),
      .mask_wdata_i  (wdata_i[NUM_CH-1:0]),
      .wr_en_task_i  (acc_wr && addr_i == A_EN),
      .wr_dis_task_i (acc_wr && addr_i == A_DIS),
      .wr_sub_en_i   (acc_wr && addr_i == A_SEN),
      .wr_sub_dis_i  (acc_wr && addr_i == A_SDIS),
      .wr_mask_i     (acc_wr && addr_i == A_MASK),
      .ch_evt_i      (ch_evt_i),
      .en_req_o      (en_req[g]),
      .dis_req_o     (dis_req[g]),
      .mask_o        (grp_mask[g]),
      .sec_o         (grp_sec[g]),
      .sub_en_on_o   (sub_en_on[g]),
      .sub_en_idx_o  (sub_en_idx[g]),
      .sub_dis_on_o  (sub_dis_on[g]),
      .sub_dis_idx_o (sub_dis_idx[g])
    );
  end

  always_comb begin
    en_chs  = '0;
    dis_chs = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (en_req[g])  en_chs  = en_chs  | grp_mask[g];
      if (dis_req[g]) dis_chs = dis_chs | grp_mask[g];
    end
  end

  chan_sec_filter_chen #(.NUM_CH(NUM_CH)) u_chen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .perm_i    (perm_i),
    .ns_i      (ns),
    .wr_chen_i (acc_wr && addr_i == CHEN_ADDR),
    .wr_set_i  (acc_wr && addr_i == SET_ADDR),
    .wr_clr_i  (acc_wr && addr_i == CLR_ADDR),
    .wbits_i   (wdata_i[NUM_CH-1:0]),
    .grp_en_i  (en_chs),
    .grp_dis_i (dis_chs),
    .chen_o    (chen_o)
  );

  assign rd_mask = ns ? ~perm_i : '1;

  always_comb begin
    rdata_o = '0;
    if (acc_rd) begin
      if (addr_i == CHEN_ADDR || addr_i == SET_ADDR || addr_i == CLR_ADDR)
        rdata_o = DATA_W'(chen_o & rd_mask);
      for (int g = 0; g < NUM_GRP; g++) begin
        if (!(ns && grp_sec[g])) begin
          if (addr_i == ADDR_W'(int'(SUB_BASE) + 2*g))
            rdata_o = {sub_en_on[g], {PAD_W{1'b0}}, sub_en_idx[g]};
          if (addr_i == ADDR_W'(int'(SUB_BASE) + 2*g + 1))
            rdata_o = {sub_dis_on[g], {PAD_W{1'b0}}, sub_dis_idx[g]};
          if (addr_i == ADDR_W'(int'(MASK_BASE) + g))
            rdata_o = DATA_W'(grp_mask[g]);
        end
      end
    end
  end
endmodule

// File: rtl/chan_sec_filter_chk.sv
module chan_sec_filter_chk
  import chan_sec_filter_pkg::*;
#(
  parameter int unsigned NUM_CH = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              sec_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NUM_CH-1:0] perm_i,
  input logic [NUM_CH-1:0] ch_evt_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] chen_o,
  input logic [NUM_CH-1:0] en_chs,
  input logic [NUM_CH-1:0] dis_chs
);
  logic chen_acc;
  assign chen_acc = req_i && (addr_i == CHEN_ADDR || addr_i == SET_ADDR || addr_i == CLR_ADDR);

  always @(posedge clk_i)
    if (!rst_ni) p_reset_clear_r1: assert (chen_o == '0);

  p_sec_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chen_acc && !we_i && sec_i) |-> rdata_o == DATA_W'(chen_o));

  p_ns_write_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chen_acc && we_i && !sec_i && ch_evt_i == '0)
    |=> ((chen_o ^ $past(chen_o)) & $past(perm_i)) == '0);

  p_ns_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chen_acc && !we_i && !sec_i) |-> (rdata_o[NUM_CH-1:0] & perm_i) == '0);

  p_en_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_chs != '0) |=> (chen_o & $past(en_chs)) == $past(en_chs));

  p_dis_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dis_chs & ~en_chs) != '0) |=> (chen_o & $past(dis_chs & ~en_chs)) == '0);
endmodule

bind chan_sec_filter chan_sec_filter_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/chan_sec_filter_test.sv
module chan_sec_filter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, sec_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [15:0] perm_i = '0;
  logic [15:0] ch_evt_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] chen_o;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  chan_sec_filter uut (.*);

  // behavioural reference
  logic [15:0] m_chen;
  logic [15:0] m_mask [6];
  bit          m_son [2][6];
  int          m_sch [2][6];

  function automatic bit m_gsec(int g);
    return (m_mask[g] & perm_i) != 0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a, bit s);
    if (a >= 8'h40 && a <= 8'h42) return {16'h0, m_chen & (s ? 16'hFFFF : ~perm_i)};
    for (int g = 0; g < 6; g++) begin
      if (!s && m_gsec(g)) continue;
      if (a == 8'h20 + 8'(2*g))     return {m_son[0][g], 27'h0, 4'(m_sch[0][g])};
      if (a == 8'h21 + 8'(2*g))     return {m_son[1][g], 27'h0, 4'(m_sch[1][g])};
      if (a == 8'h60 + 8'(g))       return {16'h0, m_mask[g]};
    end
    return 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_chen = '0;
      for (int g = 0; g < 6; g++) begin
        m_mask[g] = '0;
        for (int k = 0; k < 2; k++) begin m_son[k][g] = 0; m_sch[k][g] = 0; end
      end
    end else begin
      bit gs [6];
      logic [15:0] en_v, dis_v, wm, nxt;
      bit wr;
      wr = req_i && we_i;
      en_v = '0; dis_v = '0;
      for (int g = 0; g < 6; g++) gs[g] = m_gsec(g);
      for (int g = 0; g < 6; g++) begin
        bit blk;
        blk = !sec_i && gs[g];
        if (wr && !blk && wdata_i[0] && addr_i == 8'(2*g))     en_v  |= m_mask[g];
        if (wr && !blk && wdata_i[0] && addr_i == 8'(2*g + 1)) dis_v |= m_mask[g];
        if (m_son[0][g] && ch_evt_i[m_sch[0][g]] && (perm_i[m_sch[0][g]] || !gs[g])) en_v  |= m_mask[g];
        if (m_son[1][g] && ch_evt_i[m_sch[1][g]] && (perm_i[m_sch[1][g]] || !gs[g])) dis_v |= m_mask[g];
      end
      wm = sec_i ? 16'hFFFF : ~perm_i;
      nxt = m_chen;
      if (wr && addr_i == 8'h40) nxt = (m_chen & ~wm) | (wdata_i[15:0] & wm);
      if (wr && addr_i == 8'h41) nxt = m_chen | (wdata_i[15:0] & wm);
      if (wr && addr_i == 8'h42) nxt = m_chen & ~(wdata_i[15:0] & wm);
      m_chen = (nxt & ~dis_v) | en_v;
      for (int g = 0; g < 6; g++) begin
        if (wr && !(!sec_i && gs[g])) begin
          if (addr_i == 8'h60 + 8'(g) && !m_son[0][g] && !m_son[1][g]) m_mask[g] = wdata_i[15:0];
          for (int k = 0; k < 2; k++)
            if (addr_i == 8'h20 + 8'(2*g + k)) begin
              m_son[k][g] = wdata_i[31];
              m_sch[k][g] = int'(wdata_i[3:0]);
            end
        end
      end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) check(cur_req, "chen_o", {16'h0, chen_o}, {16'h0, m_chen});

  task automatic wr(logic [7:0] a, logic [31:0] d, bit s);
    @(negedge clk_i);
    req_i = 1; we_i = 1; sec_i = s; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, bit s);
    @(negedge clk_i);
    req_i = 1; we_i = 0; sec_i = s; addr_i = a;
    #1 check(req, $sformatf("read %h sec=%0d", a, s), rdata_o, m_read(a, s));
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic pulse(int ch);
    @(negedge clk_i);
    ch_evt_i = 16'(1) << ch;
    @(negedge clk_i);
    ch_evt_i = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "chen in reset", {16'h0, chen_o}, 32'h0);
    rst_ni = 1;
    // R1: everything reads zero after reset
    rd("R1", 8'h40, 1); rd("R1", 8'h60, 1); rd("R1", 8'h21, 1); rd("R1", 8'h65, 1);
    perm_i = 16'h00F0;
    // R2: secure full access
    cur_req = "R2";
    wr(8'h40, 32'h0000FFFF, 1);
    rd("R2", 8'h40, 1); rd("R2", 8'h41, 1);
    // R4: non-secure read masking
    cur_req = "R4";
    rd("R4", 8'h40, 0); rd("R4", 8'h41, 0); rd("R4", 8'h42, 0);
    // R3: non-secure writes keep secure bits
    cur_req = "R3";
    wr(8'h42, 32'h0000FFFF, 0);
    rd("R3", 8'h40, 1);
    wr(8'h40, 32'h00000000, 0);
    wr(8'h41, 32'h0000FFFF, 0);
    wr(8'h41, 32'h00000000, 0);
    wr(8'h42, 32'h00000000, 0);
    rd("R3", 8'h40, 1);
    wr(8'h42, 32'h0000FFFF, 1);
    // R6 / R8: groups
    cur_req = "R6";
    wr(8'h60, 32'h00000010, 1);
    wr(8'h61, 32'h00000003, 0);
    rd("R6", 8'h60, 0); rd("R6", 8'h61, 0); rd("R2", 8'h60, 1);
    wr(8'h00, 32'h1, 0);
    cur_req = "R8";
    wr(8'h02, 32'h1, 0);
    wr(8'h02, 32'h0, 1);
    wr(8'h00, 32'h1, 1);
    cur_req = "R6";
    wr(8'h01, 32'h1, 0);
    wr(8'h60, 32'h0000FFFF, 0);
    wr(8'h20, 32'h80000001, 0);
    rd("R6", 8'h60, 1); rd("R6", 8'h20, 1); rd("R6", 8'h20, 0);
    // R5: security from membership, not enable state
    cur_req = "R5";
    wr(8'h62, 32'h00000100, 0);
    rd("R5", 8'h62, 0);
    perm_i = 16'h01F0;
    rd("R5", 8'h62, 0); rd("R5", 8'h62, 1);
    wr(8'h04, 32'h1, 0);
    perm_i = 16'h00F0;
    // R7 / R8: enable wins on shared channel
    cur_req = "R8";
    wr(8'h42, 32'h0000FFFF, 1);
    wr(8'h63, 32'h00000C00, 1);
    wr(8'h64, 32'h00000800, 1);
    wr(8'h26, 32'h80000001, 1);
    wr(8'h29, 32'h80000001, 1);
    wr(8'h41, 32'h00000800, 1);
    pulse(1);
    rd("R8", 8'h40, 1);
    wr(8'h09, 32'h1, 1);
    rd("R8", 8'h40, 1);
    cur_req = "R7";
    wr(8'h63, 32'h0000FFFF, 1);
    rd("R7", 8'h63, 1);
    wr(8'h26, 32'h00000001, 1);
    wr(8'h63, 32'h00000003, 1);
    rd("R7", 8'h63, 1);
    // R9: channel pulse filtering
    cur_req = "R9";
    wr(8'h00, 32'h1, 1);
    wr(8'h21, 32'h80000002, 1);
    pulse(2);
    rd("R9", 8'h40, 1);
    wr(8'h21, 32'h80000005, 1);
    pulse(5);
    rd("R9", 8'h21, 1);
    wr(8'h22, 32'h80000006, 1);
    pulse(6);
    rd("R9", 8'h40, 1);
    // R10: unmapped and task addresses read zero
    rd("R10", 8'h00, 1); rd("R10", 8'h7F, 1); rd("R10", 8'h23, 0);
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule